// File: doc/BRIEF.md
# Flag-Paced Serial Port DMA Channel Pair

This block moves bytes between system memory and the data register of a byte-wide serial port without CPU involvement. It has two channels, one per direction. The transmit channel reads a byte from memory each time the port signals that its transmit register is empty, and writes that byte into the data register. The receive channel takes each byte the port has received out of the data register and stores it in memory. The serial port's flags pace every transfer, so the engine never runs ahead of the line.

Software programs each channel with a base address, a byte count, a priority and two interrupt enables, then pulses that channel's start input. The memory address steps by one per byte and the data register address never changes. Each channel raises a sticky half-way flag and a sticky completion flag. After its last byte the channel deactivates itself. A masking output keeps the CPU's transmit-empty interrupt quiet while transmit DMA owns that flag.

Top module: `serial_dma`

## Requirements
- R1: The transmit request (`tx_en_i`, channel active, `txe_i` high) and the receive request (`rx_en_i`, channel active, `rxne_i` high) are formed independently of each other. Memory is read only for a transmit and written only for a receive.
- R2: A granted transmit reads memory (`mem_req_o`=1, `mem_we_o`=0) at the channel address in the grant cycle. In the next cycle it asserts `dr_we_o` with `dr_wdata_o` equal to `mem_rdata_i` returned by the single-cycle-latency memory.
- R3: A granted receive asserts `dr_re_o` and, in the same cycle, writes `dr_rdata_i` to memory at the channel address (`mem_req_o`=1, `mem_we_o`=1).
- R4: The channel memory address starts at the programmed base and increases by one after each byte moved.
- R5: A channel moves at most one byte per flag assertion. After a grant it stays idle while the flag stays high, and it resumes only after the flag has been seen low at a clock edge and then high again.
- R6: A channel does nothing before its start pulse. Starting with a count of zero leaves it inactive. After the programmed number of bytes it deactivates and ignores requests until it is started again.
- R7: Bit 1 of `tx_irq_o`/`rx_irq_o` is the completion interrupt. It rises on the clock edge that completes the last byte, only if the full-interrupt enable was set at start. It stays high until a one on bit 1 of the matching clear input.
- R8: Bit 0 of the interrupt output is the half-way interrupt. It rises when the count of bytes moved reaches the programmed count divided by two (rounded down, never for a count of 1), only if enabled at start. It is cleared by bit 0 of the clear input.
- R9: When both channels request in the same idle cycle, the larger priority value wins. On equal priority the receive channel wins. The loser is served in the next idle cycle.
- R10: `txe_irq_o` equals `txe_ie_i` AND `txe_i` while `tx_en_i` is low. It is held low whenever `tx_en_i` is high.
- R11: With its enable low, an active channel makes no transfer even while its flag is high. It resumes at its current address and count once the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit DMA enable |
| tx_start_i | input | 1 | Load and activate transmit channel |
| tx_base_i | input | AW | Transmit memory start address |
| tx_len_i | input | CW | Transmit byte count |
| tx_prio_i | input | PW | Transmit priority |
| tx_half_ie_i | input | 1 | Transmit half-way interrupt enable |
| tx_full_ie_i | input | 1 | Transmit completion interrupt enable |
| tx_irq_clr_i | input | 2 | Write-one clear of transmit interrupt flags |
| tx_irq_o | output | 2 | Transmit interrupts {full, half} |
| rx_en_i | input | 1 | Receive DMA enable |
| rx_start_i | input | 1 | Load and activate receive channel |
| rx_base_i | input | AW | Receive memory start address |
| rx_len_i | input | CW | Receive byte count |
| rx_prio_i | input | PW | Receive priority |
| rx_half_ie_i | input | 1 | Receive half-way interrupt enable |
| rx_full_ie_i | input | 1 | Receive completion interrupt enable |
| rx_irq_clr_i | input | 2 | Write-one clear of receive interrupt flags |
| rx_irq_o | output | 2 | Receive interrupts {full, half} |
| txe_i | input | 1 | Port transmit register empty |
| rxne_i | input | 1 | Port has a received byte |
| txe_ie_i | input | 1 | CPU transmit-empty interrupt enable |
| txe_irq_o | output | 1 | Masked transmit-empty interrupt to CPU |
| dr_we_o | output | 1 | Data register write strobe |
| dr_wdata_o | output | DW | Data register write byte |
| dr_re_o | output | 1 | Data register read strobe |
| dr_rdata_i | input | DW | Data register read byte |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write byte |
| mem_rdata_i | input | DW | Memory read byte, one cycle after request |

## Verification
The bench goes after a receive flag that the port model leaves high after a read. A design that re-arms on the level instead of the edge would store the same byte repeatedly. It also raises both flags on the same edge under unequal and then equal priorities; a wrong tie rule would show as transmit and receive completing in swapped order against the scoreboard. Zero-length and exhausted channels are driven with live flags, where a counter that wraps or keeps going would emit stray accesses. Half-way and completion flags are sampled on the exact edge after the relevant byte and kept uncleared for several cycles, which catches off-by-one targets and flags that are not sticky.

// File: rtl/serial_dma_pkg.sv
package serial_dma_pkg;
  localparam int unsigned CH_TX    = 0;
  localparam int unsigned CH_RX    = 1;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned IRQ_HALF = 0;
  localparam int unsigned IRQ_FULL = 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_TXD  = 1'b1
  } eng_st_e;
endpackage

// File: rtl/serial_dma_chan.sv
module serial_dma_chan #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] len_i,
  input  logic [PW-1:0] prio_i,
  input  logic          half_ie_i,
  input  logic          full_ie_i,
  input  logic          en_i,
  input  logic          flag_i,
  input  logic          grant_i,
  input  logic          done_i,
  input  logic [1:0]    clr_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic [PW-1:0] prio_o,
  output logic [1:0]    irq_o
);
  import serial_dma_pkg::*;

  logic          active_q, used_q;
  logic          half_ie_q, full_ie_q, half_q, full_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] len_q, half_tgt_q, moved_q, moved_nxt;
  logic [PW-1:0] prio_q;
  logic          step;

  assign moved_nxt = moved_q + CW'(1);
  assign step      = done_i && active_q && !start_i;
  // one request per flag assertion
  assign req_o     = en_i && active_q && flag_i && !used_q;
  assign addr_o    = addr_q;
  assign prio_o    = prio_q;
  assign irq_o[IRQ_HALF] = half_q && half_ie_q;
  assign irq_o[IRQ_FULL] = full_q && full_ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      addr_q     <= '0;
      len_q      <= '0;
      half_tgt_q <= '0;
      moved_q    <= '0;
      prio_q     <= '0;
      half_ie_q  <= 1'b0;
      full_ie_q  <= 1'b0;
    end else if (start_i) begin
      active_q   <= (len_i != '0);
      addr_q     <= base_i;
      len_q      <= len_i;
      half_tgt_q <= len_i >> 1;
      moved_q    <= '0;
      prio_q     <= prio_i;
      half_ie_q  <= half_ie_i;
      full_ie_q  <= full_ie_i;
    end else if (step) begin
      moved_q <= moved_nxt;
      addr_q  <= addr_q + AW'(1);
      if (moved_nxt == len_q) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       used_q <= 1'b0;
    else if (grant_i)  used_q <= 1'b1;
    else if (!flag_i)  used_q <= 1'b0;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (step && half_tgt_q != '0 && moved_nxt == half_tgt_q) half_q <= 1'b1;
      else if (clr_i[IRQ_HALF])                                  half_q <= 1'b0;
      if (step && moved_nxt == len_q) full_q <= 1'b1;
      else if (clr_i[IRQ_FULL])        full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_dma_arb.sv
module serial_dma_arb #(
  parameter int unsigned PW = 2
) (
  input  logic          idle_i,
  input  logic          tx_req_i,
  input  logic          rx_req_i,
  input  logic [PW-1:0] tx_prio_i,
  input  logic [PW-1:0] rx_prio_i,
  output logic          tx_gnt_o,
  output logic          rx_gnt_o
);
  logic tx_wins;

  // receive takes ties so no incoming byte waits behind transmit
  assign tx_wins  = tx_req_i && (!rx_req_i || (tx_prio_i > rx_prio_i));
  assign tx_gnt_o = idle_i && tx_wins;
  assign rx_gnt_o = idle_i && rx_req_i && !tx_wins;
endmodule

// File: rtl/serial_dma.sv
module serial_dma #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 2,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          tx_start_i,
  input  logic [AW-1:0] tx_base_i,
  input  logic [CW-1:0] tx_len_i,
  input  logic [PW-1:0] tx_prio_i,
  input  logic          tx_half_ie_i,
  input  logic          tx_full_ie_i,
  input  logic [1:0]    tx_irq_clr_i,
  output logic [1:0]    tx_irq_o,
  input  logic          rx_en_i,
  input  logic          rx_start_i,
  input  logic [AW-1:0] rx_base_i,
  input  logic [CW-1:0] rx_len_i,
  input  logic [PW-1:0] rx_prio_i,
  input  logic          rx_half_ie_i,
  input  logic          rx_full_ie_i,
  input  logic [1:0]    rx_irq_clr_i,
  output logic [1:0]    rx_irq_o,
  input  logic          txe_i,
  input  logic          rxne_i,
  input  logic          txe_ie_i,
  output logic          txe_irq_o,
  output logic          dr_we_o,
  output logic [DW-1:0] dr_wdata_o,
  output logic          dr_re_o,
  input  logic [DW-1:0] dr_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  import serial_dma_pkg::*;

  logic [NUM_CH-1:0]         ch_start, ch_en, ch_flag, ch_grant, ch_done, ch_req;
  logic [NUM_CH-1:0]         ch_hie, ch_fie;
  logic [NUM_CH-1:0][AW-1:0] ch_base, ch_addr;
  logic [NUM_CH-1:0][CW-1:0] ch_len;
  logic [NUM_CH-1:0][PW-1:0] ch_prio_in, ch_prio;
  logic [NUM_CH-1:0][1:0]    ch_clr, ch_irq;

  eng_st_e st_q;
  logic    idle, tx_gnt, rx_gnt;

  assign ch_start[CH_TX]   = tx_start_i;
  assign ch_start[CH_RX]   = rx_start_i;
  assign ch_en[CH_TX]      = tx_en_i;
  assign ch_en[CH_RX]      = rx_en_i;
  assign ch_flag[CH_TX]    = txe_i;
  assign ch_flag[CH_RX]    = rxne_i;
  assign ch_base[CH_TX]    = tx_base_i;
  assign ch_base[CH_RX]    = rx_base_i;
  assign ch_len[CH_TX]     = tx_len_i;
  assign ch_len[CH_RX]     = rx_len_i;
  assign ch_prio_in[CH_TX] = tx_prio_i;
  assign ch_prio_in[CH_RX] = rx_prio_i;
  assign ch_hie[CH_TX]     = tx_half_ie_i;
  assign ch_hie[CH_RX]     = rx_half_ie_i;
  assign ch_fie[CH_TX]     = tx_full_ie_i;
  assign ch_fie[CH_RX]     = rx_full_ie_i;
  assign ch_clr[CH_TX]     = tx_irq_clr_i;
  assign ch_clr[CH_RX]     = rx_irq_clr_i;
  assign ch_grant[CH_TX]   = tx_gnt;
  assign ch_grant[CH_RX]   = rx_gnt;
  assign ch_done[CH_TX]    = (st_q == ST_TXD);
  assign ch_done[CH_RX]    = rx_gnt;
  assign tx_irq_o          = ch_irq[CH_TX];
  assign rx_irq_o          = ch_irq[CH_RX];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    serial_dma_chan #(.AW(AW), .CW(CW), .PW(PW)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (ch_start[g]),
      .base_i    (ch_base[g]),
      .len_i     (ch_len[g]),
      .prio_i    (ch_prio_in[g]),
      .half_ie_i (ch_hie[g]),
      .full_ie_i (ch_fie[g]),
      .en_i      (ch_en[g]),
      .flag_i    (ch_flag[g]),
      .grant_i   (ch_grant[g]),
      .done_i    (ch_done[g]),
      .clr_i     (ch_clr[g]),
      .req_o     (ch_req[g]),
      .addr_o    (ch_addr[g]),
      .prio_o    (ch_prio[g]),
      .irq_o     (ch_irq[g])
    );
  end

  assign idle = (st_q == ST_IDLE);

  serial_dma_arb #(.PW(PW)) i_arb (
    .idle_i    (idle),
    .tx_req_i  (ch_req[CH_TX]),
    .rx_req_i  (ch_req[CH_RX]),
    .tx_prio_i (ch_prio[CH_TX]),
    .rx_prio_i (ch_prio[CH_RX]),
    .tx_gnt_o  (tx_gnt),
    .rx_gnt_o  (rx_gnt)
  );

  // transmit needs one cycle for the memory read to return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= ST_IDLE;
    else if (tx_gnt) st_q <= ST_TXD;
    else             st_q <= ST_IDLE;
  end

  assign mem_req_o   = tx_gnt || rx_gnt;
  assign mem_we_o    = rx_gnt;
  assign mem_addr_o  = rx_gnt ? ch_addr[CH_RX] : ch_addr[CH_TX];
  assign mem_wdata_o = dr_rdata_i;
  assign dr_re_o     = rx_gnt;
  assign dr_we_o     = (st_q == ST_TXD);
  assign dr_wdata_o  = mem_rdata_i;
  assign txe_irq_o   = txe_ie_i && txe_i && !tx_en_i;
endmodule

// File: rtl/serial_dma_chk.sv
module serial_dma_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic       rx_en_i,
  input logic       tx_start_i,
  input logic       rx_start_i,
  input logic [1:0] tx_irq_clr_i,
  input logic [1:0] rx_irq_clr_i,
  input logic [1:0] tx_irq_o,
  input logic [1:0] rx_irq_o,
  input logic       txe_i,
  input logic       rxne_i,
  input logic       txe_irq_o,
  input logic       dr_we_o,
  input logic       dr_re_o,
  input logic       mem_req_o,
  input logic       mem_we_o
);
  a_r10_txe_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |-> !txe_irq_o);

  a_r2_write_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> dr_we_o);

  a_r2_write_has_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_we_o |-> $past(mem_req_o && !mem_we_o));

  a_r1_tx_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (txe_i && tx_en_i));

  a_r3_rx_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_re_o |-> (rxne_i && rx_en_i && mem_req_o && mem_we_o));

  a_r9_one_port_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dr_re_o, dr_we_o}));

  a_r7_tx_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_irq_o[1] && !tx_irq_clr_i[1] && !tx_start_i) |=> tx_irq_o[1]);

  a_r7_rx_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o[1] && !rx_irq_clr_i[1] && !rx_start_i) |=> rx_irq_o[1]);

  a_r8_rx_half_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o[0] && !rx_irq_clr_i[0] && !rx_start_i) |=> rx_irq_o[0]);
endmodule

bind serial_dma serial_dma_chk i_serial_dma_chk (.*);

// File: tb/test_serial_dma.sv
module test_serial_dma;
  localparam int unsigned AW = 16;
  localparam int unsigned CW = 16;
  localparam int unsigned PW = 2;
  localparam int unsigned DW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          tx_en = 0, tx_start = 0, tx_hie = 0, tx_fie = 0;
  logic [AW-1:0] tx_base = '0;
  logic [CW-1:0] tx_len = '0;
  logic [PW-1:0] tx_prio = '0;
  logic [1:0]    tx_clr = '0, tx_irq;
  logic          rx_en = 0, rx_start = 0, rx_hie = 0, rx_fie = 0;
  logic [AW-1:0] rx_base = '0;
  logic [CW-1:0] rx_len = '0;
  logic [PW-1:0] rx_prio = '0;
  logic [1:0]    rx_clr = '0, rx_irq;
  logic          txe, rxne, txe_ie = 0, txe_irq;
  logic          dr_we, dr_re, mem_req, mem_we;
  logic [DW-1:0] dr_wdata, dr_rdata, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  serial_dma #(.AW(AW), .CW(CW), .PW(PW), .DW(DW)) i_serial_dma (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_en_i(tx_en), .tx_start_i(tx_start), .tx_base_i(tx_base), .tx_len_i(tx_len),
    .tx_prio_i(tx_prio), .tx_half_ie_i(tx_hie), .tx_full_ie_i(tx_fie),
    .tx_irq_clr_i(tx_clr), .tx_irq_o(tx_irq),
    .rx_en_i(rx_en), .rx_start_i(rx_start), .rx_base_i(rx_base), .rx_len_i(rx_len),
    .rx_prio_i(rx_prio), .rx_half_ie_i(rx_hie), .rx_full_ie_i(rx_fie),
    .rx_irq_clr_i(rx_clr), .rx_irq_o(rx_irq),
    .txe_i(txe), .rxne_i(rxne), .txe_ie_i(txe_ie), .txe_irq_o(txe_irq),
    .dr_we_o(dr_we), .dr_wdata_o(dr_wdata), .dr_re_o(dr_re), .dr_rdata_i(dr_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return (a[7:0] * 8'd13) ^ 8'h5A;
  endfunction

  // memory model: read data one cycle after request
  logic [DW-1:0] rx_mem [0:255];
  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= pat(mem_addr);
    if (mem_req && mem_we)  rx_mem[mem_addr[7:0]] <= mem_wdata;
  end

  // serial port model
  logic          tx_auto = 1, tx_raise = 0, tx_drop = 0;
  logic          rx_push = 0, rx_drop = 0, rx_hold = 0;
  logic [DW-1:0] rx_byte = '0, rx_dr;
  logic [2:0]    tx_dly;
  assign dr_rdata = rx_dr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe <= 1'b1; tx_dly <= '0; rxne <= 1'b0; rx_dr <= '0;
    end else begin
      if (dr_we)        begin txe <= 1'b0; tx_dly <= 3'd3; end
      else if (tx_drop)  txe <= 1'b0;
      else if (tx_raise) txe <= 1'b1;
      else if (tx_dly != 0) begin
        tx_dly <= tx_dly - 3'd1;
        if (tx_dly == 3'd1 && tx_auto) txe <= 1'b1;
      end
      if (rx_push) begin rxne <= 1'b1; rx_dr <= rx_byte; end
      else if (rx_drop || (dr_re && !rx_hold)) rxne <= 1'b0;
    end
  end

  // scoreboard
  typedef struct {
    bit            is_rx;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } item_t;
  item_t exp_q[$];
  item_t it;
  int tx_seen = 0, rx_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dr_we) begin
        if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected transmit write", dr_wdata, 0);
        else begin
          it = exp_q.pop_front();
          chk(!it.is_rx, "R9", "transmit out of order", 0, 1);
          chk(dr_wdata == it.data, "R2", "transmit byte (R4 address)", dr_wdata, it.data);
        end
        tx_seen++;
      end
      if (dr_re) begin
        if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected receive read", mem_addr, 0);
        else begin
          it = exp_q.pop_front();
          chk(it.is_rx, "R9", "receive out of order", 1, 0);
          chk(mem_addr == it.addr, "R4", "receive address", mem_addr, it.addr);
          chk(mem_wdata == it.data && mem_we, "R3", "receive byte", mem_wdata, it.data);
        end
        rx_seen++;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [AW-1:0] a);
    item_t e; e.is_rx = 0; e.addr = a; e.data = pat(a); exp_q.push_back(e);
  endtask

  task automatic push_rx(input logic [AW-1:0] a, input logic [DW-1:0] d);
    item_t e; e.is_rx = 1; e.addr = a; e.data = d; exp_q.push_back(e);
  endtask

  task automatic start_tx(input logic [AW-1:0] b, input logic [CW-1:0] l,
                          input logic [PW-1:0] p, input logic h, input logic f);
    tx_base = b; tx_len = l; tx_prio = p; tx_hie = h; tx_fie = f; tx_start = 1;
    cyc(1); tx_start = 0;
  endtask

  task automatic start_rx(input logic [AW-1:0] b, input logic [CW-1:0] l,
                          input logic [PW-1:0] p, input logic h, input logic f);
    rx_base = b; rx_len = l; rx_prio = p; rx_hie = h; rx_fie = f; rx_start = 1;
    cyc(1); rx_start = 0;
  endtask

  task automatic inject(input logic [DW-1:0] d);
    rx_byte = d; rx_push = 1; cyc(1); rx_push = 0;
  endtask

  task automatic drain;
    wait (exp_q.size() == 0);
    cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s;
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(!mem_req && !dr_we && !dr_re, "R6", "idle after reset", {mem_req, dr_we, dr_re}, 0);
    chk(tx_irq == 0 && rx_irq == 0, "R7", "irqs after reset", {tx_irq, rx_irq}, 0);

    // R10: CPU transmit-empty interrupt masking
    txe_ie = 1; cyc(1);
    chk(txe_irq == 1, "R10", "txe irq with dma off", txe_irq, 1);
    tx_en = 1; cyc(3);
    chk(txe_irq == 0, "R10", "txe irq with dma on", txe_irq, 0);
    chk(tx_seen == 0, "R6", "no transfer before start", tx_seen, 0);
    txe_ie = 0;

    // transmit run, len 4: half after 2, full after 4
    for (int i = 0; i < 4; i++) push_tx(AW'(16'h0010 + i));
    start_tx(16'h0010, 4, 0, 1, 1);
    wait (tx_seen == 2); cyc(1);
    chk(tx_irq == 2'b01, "R8", "tx half at 2 of 4", tx_irq, 2'b01);
    wait (tx_seen == 4); cyc(1);
    chk(tx_irq == 2'b11, "R7", "tx full at 4 of 4", tx_irq, 2'b11);
    cyc(12);
    chk(tx_irq == 2'b11, "R7", "tx flags sticky", tx_irq, 2'b11);
    chk(tx_seen == 4, "R6", "tx stops at terminal count", tx_seen, 4);
    tx_clr = 2'b11; cyc(1); tx_clr = 2'b00; cyc(1);
    chk(tx_irq == 2'b00, "R7", "tx flags cleared", tx_irq, 0);

    // interrupts disabled at start stay low
    push_tx(16'h0020); push_tx(16'h0021);
    start_tx(16'h0020, 2, 0, 0, 0);
    drain(); cyc(4);
    chk(tx_irq == 2'b00, "R7", "tx irqs gated by enables", tx_irq, 0);

    // receive run, len 3: half after 1, full after 3
    rx_en = 1;
    start_rx(16'h0040, 3, 0, 1, 1);
    push_rx(16'h0040, 8'hA1); inject(8'hA1); cyc(1);
    chk(rx_irq == 2'b01, "R8", "rx half at 1 of 3", rx_irq, 2'b01);
    push_rx(16'h0041, 8'hB2); inject(8'hB2); cyc(2);
    push_rx(16'h0042, 8'hC3); inject(8'hC3); cyc(1);
    chk(rx_irq == 2'b11, "R7", "rx full at 3 of 3", rx_irq, 2'b11);
    chk(rx_mem[8'h40] == 8'hA1 && rx_mem[8'h41] == 8'hB2 && rx_mem[8'h42] == 8'hC3,
        "R3", "receive bytes in memory", {rx_mem[8'h40], rx_mem[8'h41], rx_mem[8'h42]},
        24'hA1B2C3);
    rx_clr = 2'b11; cyc(1); rx_clr = 2'b00; cyc(1);
    chk(rx_irq == 2'b00, "R7", "rx flags cleared", rx_irq, 0);

    // R11: enable low blocks a live flag
    start_rx(16'h0050, 4, 0, 0, 0);
    rx_en = 0;
    s = rx_seen;
    inject(8'h5C); cyc(6);
    chk(rx_seen == s && rxne == 1, "R11", "no receive while disabled", rx_seen - s, 0);
    push_rx(16'h0050, 8'h5C);
    rx_en = 1; cyc(3);
    chk(rx_seen == s + 1, "R11", "receive resumes when enabled", rx_seen - s, 1);

    // R5: flag held high after read gives only one transfer
    rx_hold = 1;
    s = rx_seen;
    push_rx(16'h0051, 8'h77); inject(8'h77); cyc(8);
    chk(rx_seen == s + 1, "R5", "one transfer per held flag", rx_seen - s, 1);
    rx_drop = 1; cyc(1); rx_drop = 0; cyc(2);
    push_rx(16'h0052, 8'h88); inject(8'h88); cyc(4);
    chk(rx_seen == s + 2, "R5", "rearmed after flag low", rx_seen - s, 2);
    rx_hold = 0; rx_drop = 1; cyc(1); rx_drop = 0; cyc(2);

    // R9: simultaneous requests, tx priority higher
    tx_auto = 0; tx_drop = 1; cyc(1); tx_drop = 0; cyc(6);
    start_tx(16'h0060, 1, 3, 0, 0);
    start_rx(16'h0070, 1, 1, 0, 0);
    push_tx(16'h0060); push_rx(16'h0070, 8'h3C);
    rx_byte = 8'h3C; rx_push = 1; tx_raise = 1; cyc(1); rx_push = 0; tx_raise = 0;
    drain(); cyc(6);
    chk(tx_seen == 7, "R9", "tx count after higher-priority round", tx_seen, 7);

    // R9: equal priority, receive first
    start_tx(16'h0061, 1, 2, 0, 0);
    start_rx(16'h0071, 1, 2, 0, 0);
    push_rx(16'h0071, 8'h4D); push_tx(16'h0061);
    rx_byte = 8'h4D; rx_push = 1; tx_raise = 1; cyc(1); rx_push = 0; tx_raise = 0;
    drain();
    chk(exp_q.size() == 0, "R9", "equal priority round drained", exp_q.size(), 0);

    // R6: zero-length start stays inactive
    start_rx(16'h0080, 0, 0, 0, 0);
    s = rx_seen;
    inject(8'h99); cyc(8);
    chk(rx_seen == s, "R6", "zero count makes no transfer", rx_seen - s, 0);
    chk(rx_irq == 2'b00, "R7", "zero count raises no irq", rx_irq, 0);
    rx_drop = 1; cyc(1); rx_drop = 0; cyc(2);

    chk(exp_q.size() == 0, "R1", "scoreboard empty at end", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule